// File: doc/BRIEF.md
# Multiply-Add Status Flag Unit

This block produces the condition-code and exception status updates for a paired instruction that starts one single-precision multiply and one single-precision add in the same cycle. The arithmetic datapaths sit outside it. They hand over the four IEEE-754 operands, the rounded sum, and per-operation raw inexact, underflow and overflow indications. The block qualifies all of this with an issue strobe.

The two operations do not contribute to the flags in the same way. The zero, negative and infinity condition codes come from the rounded sum alone. The inexact, underflow, overflow and invalid-operation exception bits merge both operations. The divide-by-zero bit is forced low. Every other condition-code bit keeps its previous value. A write port lets other instructions load both registers directly. A precision mode input selects single or maximum precision for the product. It is passed straight through to the multiply datapath and has no effect on any flag.

Top module: `mafl_status_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `cc_q` and `exc_q` to zero on that edge.
- R2: With `issue` and `wr_en` both low, `cc_q` and `exc_q` hold their values.
- R3: After an issue, `cc_q[2]` (zero) is 1 exactly when the sum has exponent 0 and fraction 0, of either sign. A denormal sum gives 0.
- R4: After an issue, `cc_q[3]` (negative) equals sum bit 31, and this includes a negative-zero sum.
- R5: After an issue, `cc_q[4]` (infinity) is 1 exactly when the sum has exponent all ones and fraction 0. A NaN sum gives 0.
- R6: An issue leaves `cc_q` bits 0, 1, 5, 6 and 7 unchanged.
- R7: After an issue, `exc_q[0]` (inexact) is `mul_inx | add_inx`, `exc_q[2]` (underflow) is `mul_unf | add_unf`, and `exc_q[3]` (overflow) is `mul_ovf | add_ovf`.
- R8: After an issue, `exc_q[1]` (divide-by-zero) is 0.
- R9: After an issue, `exc_q[4]` (invalid) is 1 exactly in two cases: one multiply operand is infinity and the other is zero (either order, any signs), or the two add operands are infinities of opposite sign. A NaN is never treated as infinity here.
- R10: `prod_rnd_max` equals `mp_mode` combinationally, and `mp_mode` has no effect on `cc_q` or `exc_q`.
- R11: `wr_en` loads `cc_q` from `wr_cc` and `exc_q` from `wr_exc` on the next edge, and it takes priority over `issue` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Paired multiply-add issue strobe |
| mp_mode | input | 1 | Product precision select (1 = maximum) |
| mul_a | input | 32 | First multiply operand |
| mul_b | input | 32 | Second multiply operand |
| add_a | input | 32 | First add operand |
| add_b | input | 32 | Second add operand |
| sum_res | input | 32 | Rounded single-precision sum |
| mul_inx | input | 1 | Product inexact |
| mul_unf | input | 1 | Product underflow |
| mul_ovf | input | 1 | Product overflow |
| add_inx | input | 1 | Sum inexact |
| add_unf | input | 1 | Sum underflow |
| add_ovf | input | 1 | Sum overflow |
| wr_en | input | 1 | Direct register load strobe |
| wr_cc | input | 8 | Condition-code load value |
| wr_exc | input | 5 | Exception load value |
| prod_rnd_max | output | 1 | Precision select forwarded to the multiplier |
| cc_q | output | 8 | Condition-code register |
| exc_q | output | 5 | Exception register |

## Verification
On every cycle the assertions check that the registers hold, reset and load as required. After each issue they also check that the preserved condition bits are unchanged, that divide-by-zero is cleared, and that each written flag matches the internal detection wires and the raw indications one edge earlier. The mode pass-through is checked at all times. The assertions cannot tell whether the detection itself classifies operands correctly. Only the bench scenarios show that: infinity times zero in both orders and with signed zeros, same-signed against opposite-signed infinities, NaN and denormal operands, and negative-zero sums.

// File: rtl/mafl_pkg.sv
`timescale 1ns/1ps
package mafl_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MAG_W  = WORD_W - 1;

  localparam int CC_W  = 8;
  localparam int EXC_W = 5;

  // condition-code bit positions written by the paired operation
  localparam int CC_ZERO_B = 2;
  localparam int CC_NEG_B  = 3;
  localparam int CC_INF_B  = 4;
  localparam logic [CC_W-1:0] CC_WR_MASK =
    CC_W'((1 << CC_ZERO_B) | (1 << CC_NEG_B) | (1 << CC_INF_B));

  // exception register layout, most significant first
  typedef struct packed {
    logic operr;
    logic ovf;
    logic unf;
    logic dz;
    logic inx;
  } exc_t;

  function automatic logic mag_is_inf(input logic [MAG_W-1:0] m);
    return (m[MAG_W-1 -: EXP_W] == '1) && (m[FRAC_W-1:0] == '0);
  endfunction

  function automatic logic mag_is_zero(input logic [MAG_W-1:0] m);
    return (m == '0);
  endfunction
endpackage

// File: rtl/mafl_operr_detect.sv
`timescale 1ns/1ps
module mafl_operr_detect
  import mafl_pkg::*;
(
  input  logic [MAG_W-1:0]  mul_a_mag,
  input  logic [MAG_W-1:0]  mul_b_mag,
  input  logic [WORD_W-1:0] add_a,
  input  logic [WORD_W-1:0] add_b,
  output logic              mul_operr,
  output logic              add_operr
);
  logic a_inf, b_inf, a_zero, b_zero;
  logic sa_inf, sb_inf, signs_differ;

  always_comb begin
    a_inf  = mag_is_inf(mul_a_mag);
    b_inf  = mag_is_inf(mul_b_mag);
    a_zero = mag_is_zero(mul_a_mag);
    b_zero = mag_is_zero(mul_b_mag);
    mul_operr = (a_inf && b_zero) || (b_inf && a_zero);

    sa_inf       = mag_is_inf(add_a[MAG_W-1:0]);
    sb_inf       = mag_is_inf(add_b[MAG_W-1:0]);
    signs_differ = add_a[WORD_W-1] ^ add_b[WORD_W-1];
    add_operr    = sa_inf && sb_inf && signs_differ;
  end
endmodule

// File: rtl/mafl_sum_codes.sv
`timescale 1ns/1ps
module mafl_sum_codes
  import mafl_pkg::*;
(
  input  logic [WORD_W-1:0] sum_res,
  output logic              sum_zero,
  output logic              sum_neg,
  output logic              sum_inf
);
  always_comb begin
    sum_zero = mag_is_zero(sum_res[MAG_W-1:0]);
    sum_inf  = mag_is_inf(sum_res[MAG_W-1:0]);
    sum_neg  = sum_res[WORD_W-1];
  end
endmodule

// File: rtl/mafl_exc_merge.sv
`timescale 1ns/1ps
module mafl_exc_merge
  import mafl_pkg::*;
(
  input  logic mul_inx,
  input  logic mul_unf,
  input  logic mul_ovf,
  input  logic add_inx,
  input  logic add_unf,
  input  logic add_ovf,
  input  logic mul_operr,
  input  logic add_operr,
  output exc_t exc_next
);
  always_comb begin
    exc_next.inx   = mul_inx | add_inx;
    exc_next.unf   = mul_unf | add_unf;
    exc_next.ovf   = mul_ovf | add_ovf;
    exc_next.dz    = 1'b0;
    exc_next.operr = mul_operr | add_operr;
  end
endmodule

// File: rtl/mafl_status_unit.sv
`timescale 1ns/1ps
module mafl_status_unit
  import mafl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              mp_mode,
  input  logic [WORD_W-1:0] mul_a,
  input  logic [WORD_W-1:0] mul_b,
  input  logic [WORD_W-1:0] add_a,
  input  logic [WORD_W-1:0] add_b,
  input  logic [WORD_W-1:0] sum_res,
  input  logic              mul_inx,
  input  logic              mul_unf,
  input  logic              mul_ovf,
  input  logic              add_inx,
  input  logic              add_unf,
  input  logic              add_ovf,
  input  logic              wr_en,
  input  logic [CC_W-1:0]   wr_cc,
  input  logic [EXC_W-1:0]  wr_exc,
  output logic              prod_rnd_max,
  output logic [CC_W-1:0]   cc_q,
  output logic [EXC_W-1:0]  exc_q
);
  logic mul_operr, add_operr;
  logic sum_zero, sum_neg, sum_inf;
  exc_t exc_next;
  logic [CC_W-1:0] cc_codes, cc_next;

  mafl_operr_detect u_operr (
    .mul_a_mag (mul_a[MAG_W-1:0]),
    .mul_b_mag (mul_b[MAG_W-1:0]),
    .add_a     (add_a),
    .add_b     (add_b),
    .mul_operr (mul_operr),
    .add_operr (add_operr)
  );

  mafl_sum_codes u_codes (
    .sum_res  (sum_res),
    .sum_zero (sum_zero),
    .sum_neg  (sum_neg),
    .sum_inf  (sum_inf)
  );

  mafl_exc_merge u_merge (
    .mul_inx   (mul_inx),
    .mul_unf   (mul_unf),
    .mul_ovf   (mul_ovf),
    .add_inx   (add_inx),
    .add_unf   (add_unf),
    .add_ovf   (add_ovf),
    .mul_operr (mul_operr),
    .add_operr (add_operr),
    .exc_next  (exc_next)
  );

  // product precision select goes straight to the multiplier
  assign prod_rnd_max = mp_mode;

  always_comb begin
    cc_codes            = '0;
    cc_codes[CC_ZERO_B] = sum_zero;
    cc_codes[CC_NEG_B]  = sum_neg;
    cc_codes[CC_INF_B]  = sum_inf;
    cc_next = (cc_q & ~CC_WR_MASK) | cc_codes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= '0;
      exc_q <= '0;
    end else if (wr_en) begin
      cc_q  <= wr_cc;
      exc_q <= wr_exc;
    end else if (issue) begin
      cc_q  <= cc_next;
      exc_q <= exc_next;
    end
  end
endmodule

// File: rtl/mafl_status_chk.sv
`timescale 1ns/1ps
module mafl_status_chk
  import mafl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              issue,
  input logic              wr_en,
  input logic [CC_W-1:0]   wr_cc,
  input logic [EXC_W-1:0]  wr_exc,
  input logic              mp_mode,
  input logic              prod_rnd_max,
  input logic [CC_W-1:0]   cc_q,
  input logic [EXC_W-1:0]  exc_q,
  input logic              mul_operr,
  input logic              add_operr,
  input logic              sum_zero,
  input logic              sum_neg,
  input logic              sum_inf,
  input logic              mul_inx,
  input logic              mul_unf,
  input logic              mul_ovf,
  input logic              add_inx,
  input logic              add_unf,
  input logic              add_ovf
);
  logic upd;
  assign upd = issue && !wr_en;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cc_q == '0) && (exc_q == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!issue && !wr_en) |=> $stable(cc_q) && $stable(exc_q));

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (rst)
    upd |=> cc_q[CC_ZERO_B] == $past(sum_zero));

  assert_neg_code_R4: assert property (@(posedge clk) disable iff (rst)
    upd |=> cc_q[CC_NEG_B] == $past(sum_neg));

  assert_inf_code_R5: assert property (@(posedge clk) disable iff (rst)
    upd |=> cc_q[CC_INF_B] == $past(sum_inf));

  assert_keep_bits_R6: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cc_q & ~CC_WR_MASK) == $past(cc_q & ~CC_WR_MASK));

  assert_merge_raw_R7: assert property (@(posedge clk) disable iff (rst)
    upd |=> exc_q[0] == $past(mul_inx | add_inx)
         && exc_q[2] == $past(mul_unf | add_unf)
         && exc_q[3] == $past(mul_ovf | add_ovf));

  assert_dz_clear_R8: assert property (@(posedge clk) disable iff (rst)
    upd |=> !exc_q[1]);

  assert_operr_R9: assert property (@(posedge clk) disable iff (rst)
    upd |=> exc_q[4] == $past(mul_operr | add_operr));

  always_comb begin
    assert_mode_pass_R10: assert (prod_rnd_max == mp_mode);
  end

  assert_load_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cc_q == $past(wr_cc) && exc_q == $past(wr_exc));
endmodule

bind mafl_status_unit mafl_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .issue        (issue),
  .wr_en        (wr_en),
  .wr_cc        (wr_cc),
  .wr_exc       (wr_exc),
  .mp_mode      (mp_mode),
  .prod_rnd_max (prod_rnd_max),
  .cc_q         (cc_q),
  .exc_q        (exc_q),
  .mul_operr    (mul_operr),
  .add_operr    (add_operr),
  .sum_zero     (sum_zero),
  .sum_neg      (sum_neg),
  .sum_inf      (sum_inf),
  .mul_inx      (mul_inx),
  .mul_unf      (mul_unf),
  .mul_ovf      (mul_ovf),
  .add_inx      (add_inx),
  .add_unf      (add_unf),
  .add_ovf      (add_ovf)
);

// File: tb/mafl_status_unit_bench.sv
`timescale 1ns/1ps
module mafl_status_unit_bench;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000;
  localparam logic [31:0] NZ   = 32'h8000_0000;
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] TWO  = 32'h4000_0000;
  localparam logic [31:0] NTWO = 32'hC000_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [31:0] DEN  = 32'h0000_0001;
  localparam logic [7:0]  KEEP = 8'hE3;

  // fl = {mul_inx, mul_unf, mul_ovf, add_inx, add_unf, add_ovf}
  // zni = {inf, neg, zero}; ex = {operr, ovf, unf, dz, inx}
  typedef struct packed {
    logic [31:0] ma, mb, aa, ab, sm;
    logic [5:0]  fl;
    logic        mp;
    logic [2:0]  zni;
    logic [4:0]  ex;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{ONE,  ONE,  ONE,  ONE,  TWO,  6'b000000, 1'b0, 3'b000, 5'b00000},
    '{PINF, PZ,   ONE,  ONE,  TWO,  6'b000000, 1'b0, 3'b000, 5'b10000},
    '{PZ,   NINF, ONE,  ONE,  NZ,   6'b000000, 1'b1, 3'b011, 5'b10000},
    '{ONE,  ONE,  PINF, NINF, QNAN, 6'b000000, 1'b0, 3'b000, 5'b10000},
    '{ONE,  ONE,  PINF, PINF, PINF, 6'b000000, 1'b1, 3'b100, 5'b00000},
    '{ONE,  ONE,  NINF, NINF, NINF, 6'b000000, 1'b0, 3'b110, 5'b00000},
    '{DEN,  ONE,  ONE,  ONE,  DEN,  6'b100000, 1'b0, 3'b000, 5'b00001},
    '{ONE,  ONE,  ONE,  ONE,  NTWO, 6'b001010, 1'b1, 3'b010, 5'b01100},
    '{PINF, ONE,  NINF, ONE,  NINF, 6'b000100, 1'b1, 3'b110, 5'b00001},
    '{QNAN, PZ,   ONE,  ONE,  PZ,   6'b010000, 1'b0, 3'b001, 5'b00100},
    '{PINF, NZ,   NZ,   NZ,   NZ,   6'b000001, 1'b0, 3'b011, 5'b11000}
  };

  logic clk = 1'b0;
  logic rst, issue, mp_mode, wr_en;
  logic [31:0] mul_a, mul_b, add_a, add_b, sum_res;
  logic mul_inx, mul_unf, mul_ovf, add_inx, add_unf, add_ovf;
  logic [7:0] wr_cc;
  logic [4:0] wr_exc;
  logic prod_rnd_max;
  logic [7:0] cc_q;
  logic [4:0] exc_q;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mafl_status_unit u_mafl_status_unit (
    .clk(clk), .rst(rst), .issue(issue), .mp_mode(mp_mode),
    .mul_a(mul_a), .mul_b(mul_b), .add_a(add_a), .add_b(add_b),
    .sum_res(sum_res), .mul_inx(mul_inx), .mul_unf(mul_unf),
    .mul_ovf(mul_ovf), .add_inx(add_inx), .add_unf(add_unf),
    .add_ovf(add_ovf), .wr_en(wr_en), .wr_cc(wr_cc), .wr_exc(wr_exc),
    .prod_rnd_max(prod_rnd_max), .cc_q(cc_q), .exc_q(exc_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_vec(input vec_t v);
    mul_a = v.ma; mul_b = v.mb; add_a = v.aa; add_b = v.ab; sum_res = v.sm;
    {mul_inx, mul_unf, mul_ovf, add_inx, add_unf, add_ovf} = v.fl;
    mp_mode = v.mp;
  endtask

  // load both registers through the write port (one edge)
  task automatic preload(input logic [7:0] c, input logic [4:0] e);
    @(negedge clk);
    wr_en = 1'b1; wr_cc = c; wr_exc = e; issue = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; issue = 1'b0; wr_en = 1'b0; wr_cc = '0; wr_exc = '0;
    apply_vec(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset cc", 32'(cc_q), 32'h0);
    check("R1 reset exc", 32'(exc_q), 32'h0);
    rst = 1'b0;

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [7:0] pc;
      logic [4:0] pe;
      pc = (i % 2 == 1) ? 8'hFF : 8'hE3 ^ 8'(i);
      pe = (i % 2 == 1) ? 5'h1F : 5'h02;
      preload(pc, pe);
      apply_vec(VECS[i]);
      issue = 1'b1;
      #1;
      check("R10 mode pass", 32'(prod_rnd_max), 32'(VECS[i].mp));
      @(negedge clk);
      issue = 1'b0;
      check("R3 zero code", 32'(cc_q[2]), 32'(VECS[i].zni[0]));
      check("R4 neg code", 32'(cc_q[3]), 32'(VECS[i].zni[1]));
      check("R5 inf code", 32'(cc_q[4]), 32'(VECS[i].zni[2]));
      check("R6 kept bits", 32'(cc_q & KEEP), 32'(pc & KEEP));
      check("R7 inx/unf/ovf", 32'(exc_q & 5'b01101), 32'(VECS[i].ex & 5'b01101));
      check("R8 dz cleared", 32'(exc_q[1]), 32'h0);
      check("R9 operr", 32'(exc_q[4]), 32'(VECS[i].ex[4]));
    end

    // R10: same operands, mode flipped, flags identical
    preload(8'h00, 5'h00);
    apply_vec(VECS[10]);
    mp_mode = 1'b1;
    issue = 1'b1;
    #1 check("R10 mode pass high", 32'(prod_rnd_max), 32'h1);
    @(negedge clk);
    issue = 1'b0;
    check("R10 cc unaffected by mode", 32'(cc_q), 32'h0C);
    check("R10 exc unaffected by mode", 32'(exc_q), 32'h18);

    // R2: idle cycles with changing inputs hold state
    preload(8'hA5, 5'h15);
    apply_vec(VECS[2]);
    repeat (3) @(negedge clk);
    check("R2 hold cc", 32'(cc_q), 32'hA5);
    check("R2 hold exc", 32'(exc_q), 32'h15);

    // R11: load wins over a simultaneous issue
    @(negedge clk);
    apply_vec(VECS[4]);
    issue = 1'b1; wr_en = 1'b1; wr_cc = 8'h5A; wr_exc = 5'h0B;
    @(negedge clk);
    issue = 1'b0; wr_en = 1'b0;
    check("R11 load priority cc", 32'(cc_q), 32'h5A);
    check("R11 load priority exc", 32'(exc_q), 32'h0B);

    // R1: reset mid-run, also over an issue
    issue = 1'b1; rst = 1'b1;
    @(negedge clk);
    issue = 1'b0; rst = 1'b0;
    check("R1 mid-run reset cc", 32'(cc_q), 32'h0);
    check("R1 mid-run reset exc", 32'(exc_q), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule